// File: doc/BRIEF.md
# Shared interrupt line aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto a small number of shared interrupt lines. Every slot has four request pins. A fixed routing rule assigns each pin to one shared line. The block keeps one counter per line. Each counter holds how many asserted pins currently drive that line, and the line is high while its counter is nonzero.

Counters do not follow the pin levels directly. They move only when a pin changes. The block stores the last seen level of every pin. A rising pin adds one to the counter of its line, and a falling pin removes one. If several pins change in the same cycle, every change is applied, and each counter takes the net result.

A parameter selects where the slots sit:
- **Directly on the bus.** The routing rule is applied once.
- **Behind one bridge.** The rule first picks one of the bridge's four pins. It is then applied again, using the bridge's own slot, to reach a real line.

Top module: `irq_share_agg`

## Requirements
- R1: While reset is asserted, all lines are low. Reset clears every counter and every stored pin level. A pin that is high when reset is released therefore counts as a new rise at the first clock edge after release.
- R2: Direct variant: pin `p` (0..3) of slot `s` drives line `(s + p) mod NLINES`. Pin `p` of slot `s` is bit `4*s + p` of `irq_lvl_i`, and line `k` is bit `k` of `line_o`.
- R3: A line is high exactly when at least one pin routed to it is high. Dropping one of two high pins that share a line keeps the line high. Dropping the last one drives the line low.
- R4: A pin held at the same level for any number of cycles does not change any line.
- R5: When pins on the same line rise and fall in the same cycle, the counter takes the net change. A swap from one high pin to another on the same line keeps the line high without a gap.
- R6: A change on `irq_lvl_i` that is present at a rising clock edge appears on `line_o` right after that edge. That is a latency of one register.
- R7: Bridge variant (`BEHIND_BRIDGE=1`): pin `p` of slot `s` first maps to bridge pin `h = (s + p) mod 4`. It then drives line `(BRIDGE_SLOT + h) mod NLINES`.
- R8: Counters never underflow or overflow. This holds with every pin high and again when all pins are released together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | NDEV*4 | Request pin levels; bit 4*slot+pin |
| line_o | output | NLINES | Shared interrupt line levels |

## Verification
The bench builds two instances from the same pin stimulus:
- **Direct instance:** `NDEV=6`, `NLINES=3`. A line count that is not a power of two exercises the modulo in the routing. Slots 0 to 5 wrap around the lines more than once, so many pins share each line.
- **Bridge instance:** `NDEV=6`, `NLINES=4`, `BEHIND_BRIDGE=1`, `BRIDGE_SLOT=2`. The nonzero bridge slot makes the second routing pass differ from the first.

Stimulus covers:
- walking single pins;
- paired pins on one line;
- same-cycle swaps;
- all pins high at once;
- a long pseudo-random sequence;
- a reset applied while pins are high.

Each instance is compared every cycle against an OR-of-pins reference model.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

   // Number of request pins every device slot owns
   localparam int PINS_PER_DEV = 4;

   // One routing hop: slot and pin number onto one of nlines lines
   function automatic int route_hop(input int slot, input int pin, input int nlines);
      return (slot + pin) % nlines;
   endfunction

   // Width needed to index n items (at least one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
   import irq_share_pkg::*;
#(
   parameter int NDEV = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NDEV*PINS_PER_DEV-1:0]   lvl_i,
   output logic [NDEV*PINS_PER_DEV-1:0]   rise_o,
   output logic [NDEV*PINS_PER_DEV-1:0]   fall_o
);

   localparam int NPINS = NDEV * PINS_PER_DEV;

   generate
      if (NPINS < PINS_PER_DEV) begin : g_bad_cfg
         $error("irq_pin_edge: NDEV must be at least 1");
      end

      for (genvar d = 0; d < NDEV; d++) begin : g_dev
         logic [PINS_PER_DEV-1:0] held_q;
         logic [PINS_PER_DEV-1:0] now_lvl;

         assign now_lvl = lvl_i[d*PINS_PER_DEV +: PINS_PER_DEV];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held_q <= '0;
            end else begin
               held_q <= now_lvl;
            end
         end

         assign rise_o[d*PINS_PER_DEV +: PINS_PER_DEV] = now_lvl & ~held_q;
         assign fall_o[d*PINS_PER_DEV +: PINS_PER_DEV] = ~now_lvl & held_q;
      end
   endgenerate

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
   parameter int NPINS   = 32,
   parameter int LW      = 2,
   parameter int CW      = 6,
   parameter int LINE_ID = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NPINS-1:0]      rise_i,
   input  logic [NPINS-1:0]      fall_i,
   input  logic [NPINS*LW-1:0]   route_i,
   output logic                  line_o
);

   localparam logic [CW:0] CMAX = (CW+1)'(NPINS);

   generate
      if ((1 << CW) <= NPINS) begin : g_bad_cw
         $error("irq_line_counter: CW too narrow for NPINS");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;
   logic [CW-1:0] up_n;
   logic [CW-1:0] dn_n;

   // Count this cycle's rises and falls on pins routed to this line
   always_comb begin
      up_n = '0;
      dn_n = '0;
      for (int k = 0; k < NPINS; k++) begin
         if (route_i[k*LW +: LW] == LW'(LINE_ID)) begin
            if (rise_i[k]) up_n = up_n + CW'(1);
            if (fall_i[k]) dn_n = dn_n + CW'(1);
         end
      end
      cnt_d = cnt_q + up_n - dn_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign line_o = (cnt_q != '0);

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_n <= cnt_q);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt_q} + {1'b0, up_n} - {1'b0, dn_n}) <= CMAX);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_n == '0 && dn_n == '0) |=> $stable(cnt_q));

   // R5
   net_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_n > dn_n) |=> line_o);

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
   import irq_share_pkg::*;
#(
   parameter int NDEV          = 8,
   parameter int NLINES        = 4,
   parameter bit BEHIND_BRIDGE = 1'b0,
   parameter int BRIDGE_SLOT   = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NDEV*PINS_PER_DEV-1:0]  irq_lvl_i,
   output logic [NLINES-1:0]             line_o
);

   localparam int NPINS = NDEV * PINS_PER_DEV;
   localparam int LW    = idx_width(NLINES);
   localparam int CW    = $clog2(NPINS + 1);

   generate
      if (NDEV < 1) begin : g_bad_ndev
         $error("irq_share_agg: NDEV must be at least 1");
      end
      if (NLINES < 1) begin : g_bad_nlines
         $error("irq_share_agg: NLINES must be at least 1");
      end
      if (BRIDGE_SLOT < 0) begin : g_bad_bslot
         $error("irq_share_agg: BRIDGE_SLOT must not be negative");
      end
   endgenerate

   logic [NPINS-1:0]    rise_w;
   logic [NPINS-1:0]    fall_w;
   logic [NPINS*LW-1:0] route_w;

   // Static routing table, one entry per pin, chosen by variant
   generate
      for (genvar g = 0; g < NPINS; g++) begin : g_route
         localparam int SLOT = g / PINS_PER_DEV;
         localparam int PIN  = g % PINS_PER_DEV;
         if (BEHIND_BRIDGE) begin : g_bridged
            localparam int HOP0 = route_hop(SLOT, PIN, PINS_PER_DEV);
            localparam int DEST = route_hop(BRIDGE_SLOT, HOP0, NLINES);
            assign route_w[g*LW +: LW] = LW'(DEST);
         end else begin : g_direct
            localparam int DEST = route_hop(SLOT, PIN, NLINES);
            assign route_w[g*LW +: LW] = LW'(DEST);
         end
      end
   endgenerate

   irq_pin_edge #(
      .NDEV (NDEV)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (irq_lvl_i),
      .rise_o (rise_w),
      .fall_o (fall_w)
   );

   generate
      for (genvar l = 0; l < NLINES; l++) begin : g_line
         logic [NPINS-1:0] pin_mask;

         for (genvar m = 0; m < NPINS; m++) begin : g_mask
            assign pin_mask[m] = (route_w[m*LW +: LW] == LW'(l));
         end

         irq_line_counter #(
            .NPINS   (NPINS),
            .LW      (LW),
            .CW      (CW),
            .LINE_ID (l)
         ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise_w),
            .fall_i  (fall_w),
            .route_i (route_w),
            .line_o  (line_o[l])
         );

         // R3
         line_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(line_o[l]) |-> ((($past(irq_lvl_i)) & pin_mask) != '0));

         // R3
         line_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(line_o[l]) |-> ((($past(irq_lvl_i)) & pin_mask) == '0));
      end
   endgenerate

endmodule

// File: tb/irq_share_agg_tb.sv
module irq_share_agg_tb;

   localparam int ND   = 6;
   localparam int NP   = ND * 4;
   localparam int NLA  = 3;
   localparam int NLB  = 4;
   localparam int BSL  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic [NLA-1:0] line_a;
   logic [NLB-1:0] line_b;

   int chk_cnt  = 0;
   int fail_cnt = 0;

   typedef struct {
      logic [NLA-1:0] a;
      logic [NLB-1:0] b;
      string          tag;
   } exp_t;

   exp_t exp_q[$];

   always #5 clk = ~clk;

   irq_share_agg #(.NDEV(ND), .NLINES(NLA), .BEHIND_BRIDGE(1'b0), .BRIDGE_SLOT(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_lvl_i(pins), .line_o(line_a));

   irq_share_agg #(.NDEV(ND), .NLINES(NLB), .BEHIND_BRIDGE(1'b1), .BRIDGE_SLOT(BSL)) u_dut_br (
      .clk(clk), .rst_n(rst_n), .irq_lvl_i(pins), .line_o(line_b));

   // Reference: direct routing, R2
   function automatic logic [NLA-1:0] ref_a(input logic [NP-1:0] v);
      logic [NLA-1:0] r = '0;
      for (int d = 0; d < ND; d++)
         for (int p = 0; p < 4; p++)
            if (v[d*4+p]) r[(d+p) % NLA] = 1'b1;
      return r;
   endfunction

   // Reference: bridged routing, R7
   function automatic logic [NLB-1:0] ref_b(input logic [NP-1:0] v);
      logic [NLB-1:0] r = '0;
      for (int d = 0; d < ND; d++)
         for (int p = 0; p < 4; p++)
            if (v[d*4+p]) r[(BSL + ((d+p) % 4)) % NLB] = 1'b1;
      return r;
   endfunction

   task automatic check_now(input string tag, input logic [NLA-1:0] ea, input logic [NLB-1:0] eb);
      chk_cnt++;
      if (line_a !== ea) begin
         fail_cnt++;
         $display("FAIL %s direct: got %b expected %b", tag, line_a, ea);
      end
      chk_cnt++;
      if (line_b !== eb) begin
         fail_cnt++;
         $display("FAIL %s bridged: got %b expected %b", tag, line_b, eb);
      end
   endtask

   // Driver: apply one pin vector and queue the result due after the next edge (R6)
   task automatic step(input logic [NP-1:0] v, input string tag);
      exp_t e;
      @(negedge clk);
      pins = v;
      e.a = ref_a(v);
      e.b = ref_b(v);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // Monitor: one expected item consumed per clock edge
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         check_now(e.tag, e.a, e.b);
      end
   end

   initial begin : watchdog
      #2000000;
      fail_cnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
      $finish;
   end

   initial begin : stim
      logic [31:0] lf;
      exp_t e;

      // R1: pins high during reset, lines must stay low
      pins = 24'h000021;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_now("R1 in reset", '0, '0);

      // R1: release; stored levels were cleared, so the high pins count as rises
      @(negedge clk);
      rst_n = 1'b1;
      e.a = ref_a(pins); e.b = ref_b(pins); e.tag = "R1 release";
      exp_q.push_back(e);

      step('0, "R3 all low");

      // R2 / R7: walk single pins
      for (int i = 0; i < NP; i++) begin
         step(NP'(1) << i, "R2 R7 walk");
         step('0, "R2 R7 clear");
      end

      // R3: idx0 (line 0) and idx6 (slot1 pin2 -> line 0)
      step(NP'(24'h000041), "R3 two on line");
      step(NP'(24'h000040), "R3 one dropped");
      step('0, "R3 last dropped");

      // R5: same-cycle swap between pins of one line
      step(NP'(24'h000001), "R5 first");
      step(NP'(24'h000040), "R5 swap");
      step('0, "R5 release");

      // R4: hold a level for many cycles
      for (int i = 0; i < 6; i++) step(NP'(24'h000804), "R4 hold");
      step('0, "R4 release");
      for (int i = 0; i < 4; i++) step('0, "R4 idle");

      // R8: every pin high, then all released together
      step('1, "R8 all high");
      step('1, "R8 all high held");
      step('0, "R8 all low");

      // R6: pseudo-random sequence, one-cycle latency checked each step
      lf = 32'h1357_9bdf;
      for (int i = 0; i < 300; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         step(lf[NP-1:0] & lf[31:32-NP], "R6 random");
      end

      // R1: reset while pins are high, asynchronous clear
      step(NP'(24'hF0000F), "R1 before reset");
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      #1;
      check_now("R1 mid-run reset", '0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      e.a = ref_a(pins); e.b = ref_b(pins); e.tag = "R1 re-release";
      exp_q.push_back(e);
      step('0, "R1 after release");

      repeat (3) @(posedge clk);
      #3;
      $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
      $finish;
   end

endmodule